// File: doc/BRIEF.md
# Serial-Output Rate-1/2 Convolutional Encoder

This block encodes a bit stream with a feed-forward convolutional code of constraint length 7. It computes two coded bits for every input bit, one per generator polynomial, and sends them out one after the other on a single-bit output. One coded bit leaves the block per cycle, so the block takes a new input bit at most once every two cycles. It signals this with `in_ready`.

A frame begins with an input bit flagged as start of frame, which clears the six-bit history register. The last data bit of a frame carries an end flag. If the tail option is set on that bit, the block feeds six zero bits through the encoder by itself. This adds twelve coded bits and leaves the history register at zero. The final coded bit of each frame is marked on `out_last`.

The merged output stream equals the input spread to every other position and multiplied by one degree-13 polynomial over GF(2). The block can be checked against that single product without modelling the two generators separately.

Top module: `conv_enc_serial`

## Requirements
- R1: The first coded bit of each pair is the XOR of the current input u and the history bits s1, s2, s3 and s6. Here s1 is the input one step back and s6 is the input six steps back (generator 1 + D + D^2 + D^3 + D^6).
- R2: The second coded bit of each pair is the XOR of u, s2, s3, s5 and s6 (generator 1 + D^2 + D^3 + D^5 + D^6).
- R3: For an input sequence u_k, output position 2k carries the first bit for input k and position 2k+1 carries the second. Together the stream equals the coefficients of I(x^2)·G(x) over GF(2), with G(x) = 1 + x + x^2 + x^4 + x^5 + x^6 + x^7 + x^11 + x^12 + x^13.
- R4: An input bit is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its first coded bit is valid in the next cycle and its second coded bit in the cycle after that. `in_ready` is low in the cycle that follows an acceptance, so two inputs are never accepted on consecutive edges.
- R5: An accepted bit with `in_sof` high is encoded with all history bits taken as zero, whatever earlier frames left behind.
- R6: When the end-of-frame bit is accepted with `flush_en` high, six zero inputs follow without a gap, adding twelve coded bits. `in_ready` stays low until they are issued, and the history register is zero afterwards.
- R7: `out_last` is high on exactly one coded bit per frame. That bit is the second bit of the end-of-frame input when no tail is added, or the second bit of the sixth tail input when a tail is added. `out_last` is never high without `out_valid`.
- R8: Cycles without an accepted input (either `in_valid` low, or `in_valid` high while `in_ready` is low) change neither the output stream nor the history register.
- R9: After reset, `out_valid` and `out_last` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input bit offered |
| in_bit | input | 1 | Data bit |
| in_sof | input | 1 | First bit of a frame; clears the history |
| in_eof | input | 1 | Last data bit of a frame |
| flush_en | input | 1 | Append the six-zero tail after the bit flagged with in_eof |
| in_ready | output | 1 | Block can accept a bit this cycle |
| out_valid | output | 1 | Coded bit present |
| out_bit | output | 1 | Coded bit, first-generator bit then second-generator bit |
| out_last | output | 1 | Final coded bit of the frame |

## Verification
The bench builds the block with its default parameters: six history stages and the two generator masks 7'h4F and 7'h6D. These values make the combined degree-13 polynomial exact, so every captured stream can be compared with I(x^2)·G(x). A single-one input shows the tap pattern of each generator on its own. The bench also feeds frames with and without the tail, idle gaps, inputs held valid while not ready, a new frame started over an unflushed history, and a frame with no start flag after a flushed one. These cover the clearing, the zero state after a tail, and the immunity to unaccepted inputs.

// File: rtl/conv_enc_pkg.sv
package conv_enc_pkg;
  // history depth (constraint length minus one)
  parameter int unsigned CE_MEM = 6;
  // generator masks: bit i selects the input delayed by i steps
  parameter logic [CE_MEM:0] CE_GEN_A = 7'h4F; // 1+D+D^2+D^3+D^6
  parameter logic [CE_MEM:0] CE_GEN_B = 7'h6D; // 1+D^2+D^3+D^5+D^6
endpackage

// File: rtl/conv_tap_core.sv
module conv_tap_core #(
  parameter int unsigned    MEM   = 6,
  parameter logic [MEM:0]   GEN_A = '1,
  parameter logic [MEM:0]   GEN_B = '1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic clr,
  input  logic u,
  output logic c_a,
  output logic c_b
);
  logic [MEM:1] hist_q, hist_d, hist_eff;
  logic [MEM:0] win, tap_a, tap_b;

  // R5: a start-of-frame bit sees an empty history
  assign hist_eff = clr ? '0 : hist_q;
  assign win      = {hist_eff, u};

  for (genvar i = 0; i <= MEM; i++) begin : g_tap
    assign tap_a[i] = GEN_A[i] & win[i];
    assign tap_b[i] = GEN_B[i] & win[i];
  end

  assign c_a = ^tap_a; // R1
  assign c_b = ^tap_b; // R2

  always_comb begin
    hist_d = hist_q;
    if (adv) hist_d = win[MEM-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end
endmodule

// File: rtl/conv_pair_ser.sv
module conv_pair_ser (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic b_a,
  input  logic b_b,
  input  logic last_in,
  output logic slot_free,
  output logic out_valid,
  output logic out_bit,
  output logic out_last
);
  logic pend_q, pend_d;
  logic hold_q, hold_d;
  logic lastp_q, lastp_d;
  logic ov_q, ov_d, ob_q, ob_d, ol_q, ol_d;

  always_comb begin
    pend_d  = pend_q;
    hold_d  = hold_q;
    lastp_d = lastp_q;
    ov_d    = 1'b0;
    ob_d    = 1'b0;
    ol_d    = 1'b0;
    if (load) begin
      ov_d    = 1'b1;
      ob_d    = b_a;
      pend_d  = 1'b1;
      hold_d  = b_b;
      lastp_d = last_in;
    end else if (pend_q) begin
      ov_d    = 1'b1;
      ob_d    = hold_q;
      ol_d    = lastp_q;
      pend_d  = 1'b0;
      lastp_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      hold_q  <= 1'b0;
      lastp_q <= 1'b0;
      ov_q    <= 1'b0;
      ob_q    <= 1'b0;
      ol_q    <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      hold_q  <= hold_d;
      lastp_q <= lastp_d;
      ov_q    <= ov_d;
      ob_q    <= ob_d;
      ol_q    <= ol_d;
    end
  end

  assign slot_free = !pend_q;
  assign out_valid = ov_q;
  assign out_bit   = ob_q;
  assign out_last  = ol_q;
endmodule

// File: rtl/conv_tail_seq.sv
module conv_tail_seq #(
  parameter int unsigned MEM = 6,
  localparam int unsigned CW = $clog2(MEM + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic slot_free,
  output logic busy,
  output logic step,
  output logic step_last
);
  logic [CW-1:0] cnt_q, cnt_d;

  assign busy      = (cnt_q != '0);
  assign step      = busy && slot_free;
  assign step_last = step && (cnt_q == CW'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (start)     cnt_d = CW'(MEM);
    else if (step) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/conv_enc_serial.sv
module conv_enc_serial
  import conv_enc_pkg::*;
#(
  parameter int unsigned  MEM   = CE_MEM,
  parameter logic [MEM:0] GEN_A = CE_GEN_A,
  parameter logic [MEM:0] GEN_B = CE_GEN_B
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_bit,
  input  logic in_sof,
  input  logic in_eof,
  input  logic flush_en,
  output logic in_ready,
  output logic out_valid,
  output logic out_bit,
  output logic out_last
);
  logic slot_free, tail_busy, tail_step, tail_last;
  logic data_acc, adv, u, clr, c_a, c_b, last_in;

  assign in_ready = slot_free && !tail_busy;
  assign data_acc = in_valid && in_ready;
  assign adv      = data_acc || tail_step;
  assign u        = data_acc ? in_bit : 1'b0;
  assign clr      = data_acc && in_sof;
  assign last_in  = tail_step ? tail_last : (data_acc && in_eof && !flush_en);

  conv_tap_core #(.MEM(MEM), .GEN_A(GEN_A), .GEN_B(GEN_B)) i_core (
    .clk(clk), .rst_n(rst_n), .adv(adv), .clr(clr), .u(u), .c_a(c_a), .c_b(c_b)
  );

  conv_tail_seq #(.MEM(MEM)) i_tail (
    .clk(clk), .rst_n(rst_n), .start(data_acc && in_eof && flush_en),
    .slot_free(slot_free), .busy(tail_busy), .step(tail_step), .step_last(tail_last)
  );

  conv_pair_ser i_ser (
    .clk(clk), .rst_n(rst_n), .load(adv), .b_a(c_a), .b_b(c_b), .last_in(last_in),
    .slot_free(slot_free), .out_valid(out_valid), .out_bit(out_bit), .out_last(out_last)
  );
endmodule

// File: rtl/conv_enc_chk.sv
module conv_enc_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic in_sof,
  input logic in_bit,
  input logic out_valid,
  input logic out_bit,
  input logic out_last,
  input logic tail_busy
);
  logic acc;
  assign acc = in_valid && in_ready;

  a_r4_first_next: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (out_valid && !in_ready));
  a_r4_second_after: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> ##2 out_valid);
  a_r5_sof_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_sof) |=> (out_bit == $past(in_bit)));
  a_r6_tail_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    tail_busy |-> !in_ready);
  a_r7_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !acc && !tail_busy) |=> !out_valid);
endmodule

bind conv_enc_serial conv_enc_chk i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_sof(in_sof), .in_bit(in_bit), .out_valid(out_valid), .out_bit(out_bit),
  .out_last(out_last), .tail_busy(tail_busy)
);

// File: tb/test_conv_enc_serial.sv
module test_conv_enc_serial;
  localparam logic [13:0] GPOLY = 14'b11100011110111;
  localparam logic [6:0]  GA    = 7'h4F;
  localparam logic [6:0]  GB    = 7'h6D;

  logic clk, rst_n, in_valid, in_bit, in_sof, in_eof, flush_en;
  logic in_ready, out_valid, out_bit, out_last;

  int checks = 0, errors = 0, rec_n = 0, b2b = 0, cyc = 0;
  bit rec_bits [0:255];
  bit rec_last [0:255];
  bit prev_acc = 0;

  conv_enc_serial i_conv_enc_serial (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit), .in_sof(in_sof),
    .in_eof(in_eof), .flush_en(flush_en), .in_ready(in_ready), .out_valid(out_valid),
    .out_bit(out_bit), .out_last(out_last)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (out_valid && rec_n < 256) begin
      rec_bits[rec_n] = out_bit;
      rec_last[rec_n] = out_last;
      rec_n++;
    end
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (prev_acc && in_valid && in_ready) b2b++;
      prev_acc <= in_valid && in_ready;
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog expired: actual %0d cycles expected below 20000", cyc);
      finish_run();
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit ref_bit(int idx, logic [63:0] d, int n);
    bit r = 1'b0;
    for (int k = 0; k < n; k++) begin
      int p = idx - 2 * k;
      if (p >= 0 && p <= 13 && d[k] && GPOLY[p]) r = ~r;
    end
    return r;
  endfunction

  // gap: idle cycles after each bit; hold: keep in_valid high with a wrong bit while not ready
  task automatic send(logic [63:0] d, int n, bit sof, bit flush, int gap, bit hold);
    rec_n = 0;
    flush_en = flush;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      while (!in_ready) begin
        in_valid = hold; in_bit = ~d[k]; in_sof = hold; in_eof = hold;
        @(negedge clk);
      end
      in_valid = 1'b1; in_bit = d[k]; in_sof = sof && (k == 0); in_eof = (k == n - 1);
      @(negedge clk);
      in_valid = hold; in_bit = ~d[k]; in_sof = hold; in_eof = hold;
      repeat (gap) @(negedge clk);
    end
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  task automatic cmp_stream(string req, logic [63:0] d, int n, bit flush);
    int exp_n = 2 * n + (flush ? 12 : 0);
    int bad = -1;
    int lc = 0, lpos = -1;
    chk(rec_n == exp_n, req, "coded bit count", rec_n, exp_n);
    for (int i = 0; i < exp_n && i < rec_n; i++)
      if (bad < 0 && rec_bits[i] != ref_bit(i, d, n)) bad = i;
    chk(bad < 0, req, "first mismatching stream index", bad, -1);
    for (int i = 0; i < rec_n; i++) if (rec_last[i]) begin lc++; lpos = i; end
    chk(lc == 1 && lpos == exp_n - 1, "R7", "last flag position", lpos, exp_n - 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(in_ready == 1'b1, "R9", "in_ready after reset", in_ready, 1);
    chk(out_valid == 1'b0, "R9", "out_valid after reset", out_valid, 0);
    chk(out_last == 1'b0, "R9", "out_last after reset", out_last, 0);
  endtask

  task automatic t_impulse();
    int bad_a = -1, bad_b = -1;
    send(64'h1, 1, 1'b1, 1'b1, 0, 1'b0);
    for (int k = 0; k < 7; k++) begin
      if (bad_a < 0 && rec_bits[2*k] != GA[k]) bad_a = k;
      if (bad_b < 0 && rec_bits[2*k+1] != GB[k]) bad_b = k;
    end
    chk(bad_a < 0, "R1", "first-generator tap index mismatch", bad_a, -1);
    chk(bad_b < 0, "R2", "second-generator tap index mismatch", bad_b, -1);
    cmp_stream("R3", 64'h1, 1, 1'b1);
  endtask

  task automatic t_plain();
    send(64'hB38F_02D5_6E1C, 40, 1'b1, 1'b0, 0, 1'b0);
    cmp_stream("R3", 64'hB38F_02D5_6E1C, 40, 1'b0);
  endtask

  task automatic t_flush();
    send(64'h9_C3A5, 20, 1'b1, 1'b1, 0, 1'b0);
    cmp_stream("R6", 64'h9_C3A5, 20, 1'b1);
    // no start flag: history must be zero after the tail
    send(64'h2B7, 10, 1'b0, 1'b0, 0, 1'b0);
    cmp_stream("R6", 64'h2B7, 10, 1'b0);
  endtask

  task automatic t_sof_clear();
    send(64'hFF, 8, 1'b1, 1'b0, 0, 1'b0);
    send(64'h5_A3C7, 20, 1'b1, 1'b0, 0, 1'b0);
    cmp_stream("R5", 64'h5_A3C7, 20, 1'b0);
  endtask

  task automatic t_gaps();
    send(64'h3D_E1F0, 24, 1'b1, 1'b1, 3, 1'b0);
    cmp_stream("R8", 64'h3D_E1F0, 24, 1'b1);
  endtask

  task automatic t_rate();
    b2b = 0;
    send(64'hC0FF_EE12, 32, 1'b1, 1'b1, 0, 1'b1);
    cmp_stream("R8", 64'hC0FF_EE12, 32, 1'b1);
    chk(b2b == 0, "R4", "accepts on consecutive edges", b2b, 0);
  endtask

  task automatic t_idle();
    int seen = 0;
    send(64'h0, 1, 1'b1, 1'b1, 0, 1'b0);
    rec_n = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_bit = i[0]; in_sof = ~i[0]; in_eof = i[1];
    end
    in_sof = 1'b0; in_eof = 1'b0;
    repeat (3) @(negedge clk);
    seen = rec_n;
    chk(seen == 0, "R8", "outputs while in_valid low", seen, 0);
    send(64'hD, 4, 1'b0, 1'b0, 0, 1'b0);
    cmp_stream("R8", 64'hD, 4, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_bit = 1'b0; in_sof = 1'b0; in_eof = 1'b0; flush_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_impulse();
    t_plain();
    t_flush();
    t_sof_clear();
    t_gaps();
    t_rate();
    t_idle();
    finish_run();
  end
endmodule